// File: doc/BRIEF.md
# Online Misrouted-Cell Fault Monitor

This block watches the cells leaving a self-routing concentrator array. Each column of the array ends in a south output that delivers cells to the output group. Each row ends in an east output where cells that lost contention are dropped. In every cell slot the monitor looks at the header of each cell present on these outputs. A header is an address vector that names the destination groups, followed by a priority field. The monitor looks for patterns that legal traffic cannot produce.

Three patterns are treated as faults:
- A south cell whose header is uniform (all zeros or all ones) points to a stuck vertical link in that column.
- A south cell whose address is empty, or whose address lacks the bit of the group this array serves, has been misrouted by a stuck control element in that column.
- A uniform header on an east output points to a stuck horizontal link in that row.

Idle cells are legal on the east outputs. They carry an empty address and an all-ones (lowest) priority, so they are never mistaken for a stuck link. A control element stuck in its pass-through state yields only legal traffic, so it raises nothing.

The first fault seen is latched together with its kind and its column or row number. It stays latched until a clear pulse. The monitor only detects and roughly locates a fault; finding the exact faulty element is left to an offline test.

Top module: `fd_misroute_mon`

## Requirements
- R1: After reset, `alarm` is 0, `fault_kind` is 0 (none) and `fault_idx` is 0. While `alarm` is 0, `fault_kind` stays 0.
- R2: Each header is `ADDR_W+PRIO_W` bits wide, with the address in the upper `ADDR_W` bits and the priority in the lower `PRIO_W` bits. A valid south cell whose whole header is all zeros or all ones latches kind 3 (vertical stuck) and the column number, visible one clock after the slot.
- R3: A valid south cell whose header is not uniform but whose address is all zeros latches kind 2 (toggle stuck) and the column number.
- R4: A valid south cell whose address is non-zero but has address bit `GRP_BIT` clear latches kind 1 (misrouted) and the column number.
- R5: A valid east cell whose whole header is all zeros or all ones latches kind 4 (horizontal stuck) and the row number.
- R6: Some valid cells raise no flag. These are an east idle cell (address all zeros, priority all ones), any east cell with a non-uniform header, and a south cell whose header is not uniform and whose address has bit `GRP_BIT` set.
- R7: A header whose valid bit is low raises no flag, whatever its value.
- R8: If several outputs report a fault in the same slot, every south event wins over every east event. Within each side, the lowest index wins.
- R9: Once `alarm` is 1, it stays 1, and kind and index are held, whatever cells arrive, until `clr` is asserted.
- R10: `clr` returns all outputs to their reset values one clock later. It takes priority over a fault in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the latched fault |
| s_vld | input | NCOL | Cell present on each south output |
| s_hdr | input | NCOL*(ADDR_W+PRIO_W) | South headers, column c at bits c*HW upward |
| e_vld | input | NROW | Cell present on each east output |
| e_hdr | input | NROW*(ADDR_W+PRIO_W) | East headers, row r at bits r*HW upward |
| alarm | output | 1 | Sticky fault alarm |
| fault_kind | output | 3 | 0 none, 1 misrouted, 2 toggle stuck, 3 vertical stuck, 4 horizontal stuck |
| fault_idx | output | IDX_W | Column (kinds 1-3) or row (kind 4) of the latched fault |

## Verification
The bound checker checks several rules on every cycle:
- The reset and clear results, and the empty kind while no alarm is raised.
- That a latched fault holds steady until cleared.
- That a slot with no valid cell never raises the alarm.
- That a uniform header on column 0 or row 0 is classified correctly.

Other behaviours can only be shown by the bench's scenarios:
- Telling toggle-stuck apart from plain misroutes.
- That idle and legal cells pass without a flag.
- The south-before-east and lowest-index ordering when several outputs fault together.
- A clear colliding with a fault.

// File: rtl/fd_pkg.sv
package fd_pkg;

    typedef enum logic [2:0] {
        FK_NONE   = 3'd0,
        FK_MISRT  = 3'd1,
        FK_TOGGLE = 3'd2,
        FK_VSTUCK = 3'd3,
        FK_HSTUCK = 3'd4
    } fkind_e;

    typedef struct packed {
        logic   hit;
        fkind_e kind;
    } fevt_t;

    localparam fevt_t NO_EVT = '{hit: 1'b0, kind: FK_NONE};

endpackage

// File: rtl/fd_south_cls.sv
module fd_south_cls
    import fd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PRIO_W  = 3,
    parameter int GRP_BIT = 2
) (
    input  logic                     vld,
    input  logic [ADDR_W+PRIO_W-1:0] hdr,
    output fevt_t                    ev
);
    localparam int HW = ADDR_W + PRIO_W;

    logic [ADDR_W-1:0] addr;
    logic              uniform;

    assign addr    = hdr[HW-1:PRIO_W];
    assign uniform = (hdr == '0) || (&hdr);

    always_comb begin
        ev = NO_EVT;
        if (vld) begin
            if (uniform) begin
                ev = '{hit: 1'b1, kind: FK_VSTUCK};
            end else if (addr == '0) begin
                ev = '{hit: 1'b1, kind: FK_TOGGLE};
            end else if (!addr[GRP_BIT]) begin
                ev = '{hit: 1'b1, kind: FK_MISRT};
            end
        end
    end
endmodule

// File: rtl/fd_east_cls.sv
module fd_east_cls
    import fd_pkg::*;
#(
    parameter int HW = 11
) (
    input  logic          vld,
    input  logic [HW-1:0] hdr,
    output fevt_t         ev
);
    always_comb begin
        ev = NO_EVT;
        if (vld && ((hdr == '0) || (&hdr))) begin
            ev = '{hit: 1'b1, kind: FK_HSTUCK};
        end
    end
endmodule

// File: rtl/fd_pick.sv
module fd_pick
    import fd_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  fevt_t          ev [N],
    output logic           hit,
    output fkind_e         kind,
    output logic [IW-1:0]  idx
);
    always_comb begin
        hit  = 1'b0;
        kind = FK_NONE;
        idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ev[i].hit) begin
                hit  = 1'b1;
                kind = ev[i].kind;
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fd_misroute_mon.sv
module fd_misroute_mon
    import fd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PRIO_W  = 3,
    parameter int NCOL    = 4,
    parameter int NROW    = 4,
    parameter int GRP_BIT = 2,
    parameter int IDX_W   = $clog2((NCOL > NROW) ? NCOL : NROW)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic [NCOL-1:0]                 s_vld,
    input  logic [NCOL*(ADDR_W+PRIO_W)-1:0] s_hdr,
    input  logic [NROW-1:0]                 e_vld,
    input  logic [NROW*(ADDR_W+PRIO_W)-1:0] e_hdr,
    output logic                            alarm,
    output logic [2:0]                      fault_kind,
    output logic [IDX_W-1:0]                fault_idx
);
    localparam int HW = ADDR_W + PRIO_W;

    fevt_t s_ev [NCOL];
    fevt_t e_ev [NROW];

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        fd_south_cls #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .GRP_BIT(GRP_BIT)) u_cls (
            .vld (s_vld[c]),
            .hdr (s_hdr[c*HW +: HW]),
            .ev  (s_ev[c])
        );
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        fd_east_cls #(.HW(HW)) u_cls (
            .vld (e_vld[r]),
            .hdr (e_hdr[r*HW +: HW]),
            .ev  (e_ev[r])
        );
    end

    logic             s_hit, e_hit;
    fkind_e           s_kind, e_kind;
    logic [IDX_W-1:0] s_idx, e_idx;

    fd_pick #(.N(NCOL), .IW(IDX_W)) u_pick_s (
        .ev (s_ev), .hit (s_hit), .kind (s_kind), .idx (s_idx)
    );
    fd_pick #(.N(NROW), .IW(IDX_W)) u_pick_e (
        .ev (e_ev), .hit (e_hit), .kind (e_kind), .idx (e_idx)
    );

    logic             alarm_q;
    fkind_e           kind_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            alarm_q <= 1'b0;
            kind_q  <= FK_NONE;
            idx_q   <= '0;
        end else if (!alarm_q && (s_hit || e_hit)) begin
            alarm_q <= 1'b1;
            kind_q  <= s_hit ? s_kind : e_kind;
            idx_q   <= s_hit ? s_idx  : e_idx;
        end
    end

    assign alarm      = alarm_q;
    assign fault_kind = kind_q;
    assign fault_idx  = idx_q;
endmodule

// File: rtl/fd_mon_chk.sv
module fd_mon_chk #(
    parameter int ADDR_W  = 8,
    parameter int PRIO_W  = 3,
    parameter int NCOL    = 4,
    parameter int NROW    = 4,
    parameter int GRP_BIT = 2,
    parameter int IDX_W   = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            clr,
    input logic [NCOL-1:0]                 s_vld,
    input logic [NCOL*(ADDR_W+PRIO_W)-1:0] s_hdr,
    input logic [NROW-1:0]                 e_vld,
    input logic [NROW*(ADDR_W+PRIO_W)-1:0] e_hdr,
    input logic                            alarm,
    input logic [2:0]                      fault_kind,
    input logic [IDX_W-1:0]                fault_idx
);
    localparam int HW = ADDR_W + PRIO_W;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!alarm && fault_kind == 3'd0 && fault_idx == '0));

    p_no_kind_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !alarm |-> fault_kind == 3'd0);

    p_vstuck_col0_r2: assert property (@(posedge clk) disable iff (rst)
        (!alarm && !clr && s_vld[0] && (&s_hdr[HW-1:0]))
        |=> (fault_kind == 3'd3 && fault_idx == '0));

    p_hstuck_row0_r5: assert property (@(posedge clk) disable iff (rst)
        (!alarm && !clr && s_vld == '0 && e_vld[0] && e_hdr[HW-1:0] == '0)
        |=> (fault_kind == 3'd4 && fault_idx == '0));

    p_quiet_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (!alarm && s_vld == '0 && e_vld == '0) |=> !alarm);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (alarm && !clr) |=> (alarm && $stable(fault_kind) && $stable(fault_idx)));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!alarm && fault_kind == 3'd0 && fault_idx == '0));
endmodule

bind fd_misroute_mon fd_mon_chk #(
    .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .NCOL(NCOL),
    .NROW(NROW), .GRP_BIT(GRP_BIT), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_fd_misroute_mon.sv
module sim_fd_misroute_mon;
    localparam int AW = 8, PW = 3, HW = AW + PW, NC = 4, NR = 4, IW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1, clr = 1'b0;
    logic [NC-1:0]    s_vld = '0;
    logic [NC*HW-1:0] s_hdr = '0;
    logic [NR-1:0]    e_vld = '0;
    logic [NR*HW-1:0] e_hdr = '0;
    logic             alarm;
    logic [2:0]       fault_kind;
    logic [IW-1:0]    fault_idx;

    int errs = 0, checks = 0;

    always #5 clk = ~clk;

    fd_misroute_mon #(.ADDR_W(AW), .PRIO_W(PW), .NCOL(NC), .NROW(NR),
                      .GRP_BIT(2), .IDX_W(IW)) u0 (.*);

    localparam logic [HW-1:0] H_LEGAL = {8'b0000_0100, 3'b010};
    localparam logic [HW-1:0] H_LEGAL2 = {8'b1010_0110, 3'b000};
    localparam logic [HW-1:0] H_ONES  = '1;
    localparam logic [HW-1:0] H_ZERO  = '0;
    localparam logic [HW-1:0] H_TGL   = {8'b0, 3'b010};
    localparam logic [HW-1:0] H_MIS   = {8'b0000_0010, 3'b001};
    localparam logic [HW-1:0] H_IDLE  = {8'b0, 3'b111};

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_s(int c, logic [HW-1:0] h);
        s_vld[c] = 1'b1;
        s_hdr[c*HW +: HW] = h;
    endtask

    task automatic put_e(int r, logic [HW-1:0] h);
        e_vld[r] = 1'b1;
        e_hdr[r*HW +: HW] = h;
    endtask

    // Apply the staged cells for one slot; outputs are sampled one clock later.
    task automatic slot;
        @(negedge clk);
        s_vld = '0; e_vld = '0; s_hdr = '0; e_hdr = '0;
    endtask

    task automatic expect_fault(string req, int kind, int idx);
        check({req, " alarm"}, int'(alarm), 1);
        check({req, " kind"}, int'(fault_kind), kind);
        check({req, " idx"}, int'(fault_idx), idx);
    endtask

    task automatic do_clear;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 alarm", int'(alarm), 0);
        check("R1 kind", int'(fault_kind), 0);
        check("R1 idx", int'(fault_idx), 0);
    endtask

    task automatic t_legal;
        for (int c = 0; c < NC; c++) put_s(c, (c % 2 == 0) ? H_LEGAL : H_LEGAL2);
        for (int r = 0; r < NR; r++) put_e(r, (r == 2) ? H_MIS : H_IDLE);
        slot();
        check("R6 legal/idle no alarm", int'(alarm), 0);
        check("R6 kind none", int'(fault_kind), 0);
    endtask

    task automatic t_invalid;
        s_hdr[2*HW +: HW] = H_ONES;
        s_hdr[0 +: HW]    = H_TGL;
        e_hdr[1*HW +: HW] = H_ZERO;
        slot();
        check("R7 invalid ignored", int'(alarm), 0);
    endtask

    task automatic t_vstuck;
        put_s(2, H_ONES);
        slot();
        expect_fault("R2 ones col2", 3, 2);
        do_clear();
        put_s(1, H_ZERO);
        slot();
        expect_fault("R2 zeros col1", 3, 1);
        do_clear();
    endtask

    task automatic t_toggle;
        put_s(3, H_TGL);
        slot();
        expect_fault("R3 toggle col3", 2, 3);
        do_clear();
    endtask

    task automatic t_misroute;
        put_s(0, H_MIS);
        slot();
        expect_fault("R4 misroute col0", 1, 0);
        do_clear();
    endtask

    task automatic t_hstuck;
        put_e(2, H_ZERO);
        slot();
        expect_fault("R5 zeros row2", 4, 2);
        do_clear();
        put_e(3, H_ONES);
        slot();
        expect_fault("R5 ones row3", 4, 3);
        do_clear();
    endtask

    task automatic t_priority;
        put_s(3, H_MIS);
        put_s(1, H_TGL);
        put_e(0, H_ONES);
        slot();
        expect_fault("R8 south first lowest col", 2, 1);
        do_clear();
        put_e(3, H_ZERO);
        put_e(1, H_ONES);
        slot();
        expect_fault("R8 lowest row", 4, 1);
        do_clear();
    endtask

    task automatic t_sticky;
        put_s(2, H_ONES);
        slot();
        put_e(0, H_ZERO);
        put_s(0, H_MIS);
        slot();
        expect_fault("R9 held", 3, 2);
        repeat (3) @(negedge clk);
        expect_fault("R9 held later", 3, 2);
    endtask

    task automatic t_clear;
        clr = 1'b1;
        put_s(1, H_TGL);
        slot();
        clr = 1'b0;
        check("R10 clear wins alarm", int'(alarm), 0);
        check("R10 clear kind", int'(fault_kind), 0);
        check("R10 clear idx", int'(fault_idx), 0);
        @(negedge clk);
        check("R10 stays clear", int'(alarm), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_legal();
        t_invalid();
        t_vstuck();
        t_toggle();
        t_misroute();
        t_hstuck();
        t_priority();
        t_sticky();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule